// File: doc/BRIEF.md
# External Memory Strobe Timing Sequencer

This block runs one access at a time on an external parallel memory bus. A host presents a read or write request with an address and, for writes, data. The sequencer then drives the address bus, the write-data bus with its drive enable, and one active-low strobe (read or write) through three phases. First the address settles, then the strobe is held low, then the address is held after the strobe rises. Read data is captured from the bus while the read strobe is still low.

The length of each phase is set at run time by an 8-bit timing register that the host can read and write. It packs a 2-bit setup count, a 4-bit pulse-width code and a 2-bit hold count. The pulse-width code is biased by one, so a code of zero still gives a strobe of one clock. Each request takes a private copy of the register when it is accepted. The host can therefore retune the bus while an access is running without disturbing it.

Top module: `ext_mem_seq`

## Requirements
- R1: After reset the timing register reads 0xFF, busy and done are low, both strobes are high, the data drive enable is low, and the address and write-data buses are zero. A request issued before any register write takes 3 + 16 + 3 = 22 busy cycles.
- R2: A write on the register port shows on `cfg_rdata` from the next cycle. Bits 7:6 are the setup count S, bits 5:2 are the width code W, and bits 1:0 are the hold count H.
- R3: The first phase after acceptance lasts S cycles. During it the address is driven and both strobes are high. S = 0 removes the phase.
- R4: The strobe phase lasts W+1 cycles in one unbroken run. `mem_rd_n` is low for reads and `mem_wr_n` is low for writes. The two are never low together, and both are high whenever busy is low.
- R5: The hold phase follows the strobe and lasts H cycles. During it the address is still driven and both strobes are high. H = 0 removes the phase.
- R6: Busy is high for exactly S + W + 1 + H consecutive cycles per access. This holds for all 256 register values and for both reads and writes.
- R7: Over the whole busy window, the address and write data stay at the values given with the request. `mem_oe` is high throughout a write and low throughout a read. Outside busy, the address and write-data buses are zero.
- R8: `rd_data` takes the value of `mem_din` at the clock edge that ends the last strobe cycle of a read. It keeps that value until the next read completes its strobe. Writes leave it unchanged.
- R9: `done` is high for exactly one cycle. That cycle directly follows the last busy cycle, and busy is low in it.
- R10: A request is accepted only while busy is low. `req_valid` while busy is high is ignored: it does not change the running access and does not start one later.
- R11: A register write during an access, or in the same cycle as the request is accepted, does not change that access. It applies from the next accepted request onward.
- R12: A request presented in the done cycle is accepted. Busy rises again in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for the timing register |
| cfg_wdata | input | 8 | New timing register value |
| cfg_rdata | output | 8 | Current timing register value |
| req_valid | input | 1 | Request an access, sampled while busy is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Data for a write access |
| busy | output | 1 | Access in progress (setup, strobe or hold phase) |
| done | output | 1 | One-cycle pulse after the last busy cycle |
| rd_data | output | DW | Data captured by the last read |
| mem_addr | output | AW | External address bus |
| mem_dout | output | DW | External write-data bus |
| mem_oe | output | 1 | Drive enable for the write-data bus |
| mem_din | input | DW | External read-data bus |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |

## Verification
Two collisions are forced on purpose. First, a register write is raised in the same cycle as a request is accepted. The access must run on the old timing and the next one on the new timing, which is judged by counting busy cycles. Second, a request is held high through a done cycle. Busy must rise again in the very next cycle while done pulses once, so busy and done alternate. The read bus changes value on every clock, so the captured value shows exactly which edge sampled it.

// File: rtl/ems_pkg.sv
package ems_pkg;

  localparam int SET_W = 2;
  localparam int PW_W  = 4;
  localparam int HLD_W = 2;
  localparam int CFG_W = SET_W + PW_W + HLD_W;
  localparam int CNT_W = (PW_W > SET_W) ? ((PW_W > HLD_W) ? PW_W : HLD_W)
                                        : ((SET_W > HLD_W) ? SET_W : HLD_W);

  localparam logic [CFG_W-1:0] CFG_RESET = '1;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  // packed MSB first: setup[7:6], width[5:2], hold[1:0]
  typedef struct packed {
    logic [SET_W-1:0] setup;
    logic [PW_W-1:0]  width;
    logic [HLD_W-1:0] hold;
  } timing_t;

endpackage

// File: rtl/ems_rst_sync.sv
module ems_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ems_timing_reg.sv
module ems_timing_reg
  import ems_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output timing_t          tim
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign rdata = cfg_q;
  assign tim   = timing_t'(cfg_q);

endmodule

// File: rtl/ems_phase_ctrl.sv
module ems_phase_ctrl
  import ems_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  timing_t cfg_tim,
  output logic    start,
  output logic    busy,
  output logic    done,
  output logic    strobe,
  output logic    last_strobe
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  timing_t          tim_q, tim_d;
  logic             tim_en;

  // a new access may begin when idle or in the done cycle
  always_comb begin
    start = req_valid && ((ph_q == PH_IDLE) || (ph_q == PH_DONE));
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    tim_d  = cfg_tim;
    tim_en = start;
    case (ph_q)
      PH_IDLE, PH_DONE: begin
        if (start) begin
          if (cfg_tim.setup != '0) begin
            ph_d  = PH_SETUP;
            cnt_d = CNT_W'(cfg_tim.setup) - CNT_W'(1);
          end else begin
            ph_d  = PH_STROBE;
            cnt_d = CNT_W'(cfg_tim.width);
          end
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = CNT_W'(tim_q.width);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          if (tim_q.hold != '0) begin
            ph_d  = PH_HOLD;
            cnt_d = CNT_W'(tim_q.hold) - CNT_W'(1);
          end else begin
            ph_d = PH_DONE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          ph_d = PH_DONE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tim_q <= timing_t'(CFG_RESET);
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (tim_en) begin
        tim_q <= tim_d;
      end
    end
  end

  assign busy        = (ph_q == PH_SETUP) || (ph_q == PH_STROBE) || (ph_q == PH_HOLD);
  assign done        = (ph_q == PH_DONE);
  assign strobe      = (ph_q == PH_STROBE);
  assign last_strobe = strobe && (cnt_q == '0);

endmodule

// File: rtl/ems_bus_drv.sv
module ems_bus_drv #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          busy,
  input  logic          strobe,
  input  logic          last_strobe,
  input  logic [DW-1:0] mem_din,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_oe,
  output logic          mem_rd_n,
  output logic          mem_wr_n
);

  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          req_en, cap_en;

  always_comb begin
    req_en  = start;
    wr_d    = req_write;
    addr_d  = req_addr;
    wdata_d = req_write ? req_wdata : '0;
    cap_en  = last_strobe && !wr_q;
    rd_d    = mem_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_en) begin
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data  = rd_q;
  assign mem_addr = busy ? addr_q : '0;
  assign mem_dout = (busy && wr_q) ? wdata_q : '0;
  assign mem_oe   = busy && wr_q;
  assign mem_rd_n = !(strobe && !wr_q);
  assign mem_wr_n = !(strobe && wr_q);

endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ems_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_oe,
  input  logic [DW-1:0]    mem_din,
  output logic             mem_rd_n,
  output logic             mem_wr_n
);

  logic    rst_sync_n;
  timing_t cur_tim;
  logic    start, strobe, last_strobe;

  ems_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ems_timing_reg u_treg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .tim   (cur_tim)
  );

  ems_phase_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .cfg_tim     (cur_tim),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .strobe      (strobe),
    .last_strobe (last_strobe)
  );

  ems_bus_drv #(.AW(AW), .DW(DW)) u_drv (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .busy        (busy),
    .strobe      (strobe),
    .last_strobe (last_strobe),
    .mem_din     (mem_din),
    .rd_data     (rd_data),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_oe      (mem_oe),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n)
  );

endmodule

// File: rtl/ems_checker.sv
module ems_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr_en,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_rdata,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_oe,
  input logic          mem_rd_n,
  input logic          mem_wr_n
);

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rdata == $past(cfg_wdata)));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_rd_n && mem_wr_n && !mem_oe));

  p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_dout) && $stable(mem_oe)));

  p_busy_ends_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_spurious_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> !busy);

endmodule

bind ext_mem_seq ems_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_dout  (mem_dout),
  .mem_oe    (mem_oe),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n)
);

// File: tb/sim_ext_mem_seq.sv
module sim_ext_mem_seq;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [7:0]    cfg_wdata;
  logic [7:0]    cfg_rdata;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy, done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic          mem_oe;
  logic [DW-1:0] mem_din;
  logic          mem_rd_n, mem_wr_n;

  always #5 clk = ~clk;

  ext_mem_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_oe(mem_oe),
    .mem_din(mem_din), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string sect  = "R1";
  bit    chk_on = 1'b0;

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int            ph;    // 0 idle, 1 setup, 2 strobe, 3 hold, 4 done
    bit            busy, done, rd_n, wr_n, oe, cap;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout;
  } exp_t;

  exp_t          q[$];
  exp_t          cur;
  logic [7:0]    cfg_m;
  logic [DW-1:0] rd_m;
  bit            acc;
  int            s_m, w_m, h_m;

  function automatic exp_t mk(int ph, bit wr, bit cap, logic [AW-1:0] a, logic [DW-1:0] d);
    exp_t e;
    e.ph   = ph;
    e.busy = (ph >= 1 && ph <= 3);
    e.done = (ph == 4);
    e.rd_n = !(ph == 2 && !wr);
    e.wr_n = !(ph == 2 && wr);
    e.oe   = e.busy && wr;
    e.addr = e.busy ? a : '0;
    e.dout = (e.busy && wr) ? d : '0;
    e.cap  = cap;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cur   = mk(0, 1'b0, 1'b0, '0, '0);
      q.delete();
      cfg_m = 8'hFF;
      rd_m  = '0;
    end else begin
      acc = req_valid && !cur.busy;
      if (cur.cap) rd_m = mem_din;
      s_m = int'(cfg_m[7:6]);
      w_m = int'(cfg_m[5:2]) + 1;
      h_m = int'(cfg_m[1:0]);
      if (cfg_wr_en) cfg_m = cfg_wdata;
      if (acc) begin
        for (int i = 0; i < s_m; i++) q.push_back(mk(1, req_write, 1'b0, req_addr, req_wdata));
        for (int i = 0; i < w_m; i++)
          q.push_back(mk(2, req_write, !req_write && (i == w_m - 1), req_addr, req_wdata));
        for (int i = 0; i < h_m; i++) q.push_back(mk(3, req_write, 1'b0, req_addr, req_wdata));
        q.push_back(mk(4, req_write, 1'b0, req_addr, req_wdata));
      end
      if (q.size() > 0) cur = q.pop_front();
      else              cur = mk(0, 1'b0, 1'b0, '0, '0);
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", r, sect, act, exp, $time);
    end
  endtask

  // compare every cycle, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (chk_on) begin
      string ts;
      ts = (cur.ph == 1) ? "R3 strobe in setup" :
           (cur.ph == 3) ? "R5 strobe in hold" : "R4 strobe";
      chk("R6 busy", busy, cur.busy);
      chk("R9 done", done, cur.done);
      chk({ts, " rd_n"}, mem_rd_n, cur.rd_n);
      chk({ts, " wr_n"}, mem_wr_n, cur.wr_n);
      chk("R7 oe", mem_oe, cur.oe);
      chk("R7 addr", mem_addr, cur.addr);
      chk("R7 dout", mem_dout, cur.dout);
      chk("R8 rd_data", rd_data, rd_m);
      chk("R2 cfg_rdata", cfg_rdata, cfg_m);
    end
  end

  // read bus changes every cycle so the capture edge is visible
  always @(negedge clk) mem_din <= mem_din + 8'h3B;

  // ---------------- stimulus tasks (entered and left at a negedge) ----------------
  task automatic cfg_write(input logic [7:0] v);
    cfg_wr_en = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, output int n);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (busy === 1'b1) begin
      n++;
      @(negedge clk);
    end
    chk("R9 done after busy", done, 1'b1);
  endtask

  function automatic int len_of(logic [7:0] c);
    return int'(c[7:6]) + int'(c[5:2]) + 1 + int'(c[1:0]);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mem_din = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    sect = "R1";
    chk("R1 cfg reset", cfg_rdata, 8'hFF);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 rd_n", mem_rd_n, 1'b1);
    chk("R1 wr_n", mem_wr_n, 1'b1);
    chk("R1 oe", mem_oe, 1'b0);
    chk("R1 addr", mem_addr, '0);
    chk("R1 dout", mem_dout, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    xfer(1'b0, 16'h0F0F, 8'h00, n);
    chk("R1 default length", n, 22);

    // R2: register readback and field placement (S=1, W=2 -> 3 cycles, H=2)
    sect = "R2";
    cfg_write(8'hA5);
    chk("R2 readback", cfg_rdata, 8'hA5);
    cfg_write(8'h4A);
    xfer(1'b1, 16'h1234, 8'h5C, n);
    chk("R2 field decode", n, 6);

    // R3 / R5: phases skipped when zero
    sect = "R3";
    cfg_write(8'h0C);
    xfer(1'b0, 16'h00AA, 8'h00, n);
    chk("R3 no setup phase", n, 4);
    sect = "R5";
    cfg_write(8'hC0);
    xfer(1'b1, 16'h0055, 8'hE1, n);
    chk("R5 no hold phase", n, 4);

    // R6: all 256 codes, read and write
    sect = "R6";
    for (int c = 0; c < 256; c++) begin
      for (int w = 0; w < 2; w++) begin
        cfg_write(8'(c));
        xfer(w[0], 16'(c * 257 + w), 8'(c ^ 8'h96), n);
        chk("R6 busy length", n, len_of(8'(c)));
      end
    end

    // R10: requests while busy are ignored
    sect = "R10";
    cfg_write(8'h5A);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h1234; req_wdata = '0;
    @(negedge clk);
    n = 0;
    repeat (3) begin
      if (busy) n++;
      req_valid = 1'b1; req_addr = 16'hBEEF; req_write = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (busy === 1'b1) begin n++; @(negedge clk); end
    chk("R10 length unchanged", n, 10);
    @(negedge clk);
    chk("R10 no late start", busy, 1'b0);

    // R11: register write in flight applies only later
    sect = "R11";
    cfg_write(8'hFF);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h7777;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    repeat (5) begin if (busy) n++; @(negedge clk); end
    cfg_wr_en = 1'b1; cfg_wdata = 8'h00;
    if (busy) n++;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    while (busy === 1'b1) begin n++; @(negedge clk); end
    chk("R11 in-flight keeps timing", n, 22);
    xfer(1'b0, 16'h0101, 8'h00, n);
    chk("R11 next uses new timing", n, 1);
    // write and accept in the same cycle: old value applies
    cfg_wr_en = 1'b1; cfg_wdata = 8'hFF;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2222; req_wdata = 8'h33;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    n = 0;
    while (busy === 1'b1) begin n++; @(negedge clk); end
    chk("R11 same-cycle write uses old", n, 1);
    xfer(1'b1, 16'h2323, 8'h44, n);
    chk("R11 following uses new", n, 22);

    // R12: request held through the done cycle
    sect = "R12";
    cfg_write(8'h00);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4321;
    repeat (3) begin
      @(negedge clk);
      chk("R12 busy again", busy, 1'b1);
      @(negedge clk);
      chk("R12 done between", done, 1'b1);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 idle after release", busy, 1'b0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule